// File: doc/BRIEF.md
# Transaction Store Starvation Tracker

This block follows the priority state of one transaction store in a memory controller scheduler. It watches two inputs. The first says whether the store holds a pending transaction. The second strobes when a transaction from the store is serviced. It moves through three states: normal, critical and cool-down (a forced non-critical hold). Its critical output tells the arbiter to favour this store.

A tick arrives every 32 clock cycles, either from an internal free-running counter or from an outside source. Starvation is measured in these ticks. When a transaction has waited, without service, for the programmed number of ticks, the store becomes critical. It stays critical until the programmed run of transactions has been serviced. It then enters cool-down for a programmed number of cycles, during which it cannot be critical, and then returns to normal.

A scheduler places one instance per store (write, low-priority read, high-priority read). Each instance has its own set of the three programmable fields.

The states and transitions are:
- NORMAL to CRIT: on the tick that reaches the starvation limit.
- CRIT to COOL: on the service strobe that completes the run.
- COOL to NORMAL: once the hold count has elapsed.

The state stays where it is in every other case.

Top module: `xs_starve_tracker`

## Requirements
- R1: With the internal tick source (default), a tick occurs every 32 cycles. The first tick is consumed by the 32nd rising edge after reset is released. A NORMAL-to-CRIT change can only happen on an edge that consumes a tick.
- R2: Reset puts the block in NORMAL with `crit_o` low. `state_o` uses these codes: 0 = NORMAL, 1 = CRIT, 2 = COOL. Code 3 never appears.
- R3: In NORMAL, the block goes to CRIT on the edge of the tick that brings the count of consecutive pending, unserviced ticks to max(`starve_lim_i`, 1). `state_o` shows the change after that edge.
- R4: The starvation count returns to zero in any cycle where `svc_i` is high or `pend_i` is low. After such a cycle, a full new set of ticks is needed.
- R5: In CRIT, the block goes to COOL on the edge of the `svc_i` strobe that completes max(`run_len_i`, 1) services counted since CRIT was entered.
- R6: COOL lasts exactly max(`hold_min_i`, 1) cycles. The block is then in NORMAL.
- R7: `crit_o` is high exactly when the state is CRIT. It stays low throughout COOL, even with `pend_i` high and ticks passing.
- R8: The programmable fields are read at every comparison. A new limit written part-way through a count is used at the next tick.
- R9: In CRIT, the block stays in CRIT while no service strobe arrives, even if `pend_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ext_i | input | 1 | Outside tick pulse, used only when USE_EXT_TICK = 1 |
| pend_i | input | 1 | Store has at least one pending transaction |
| svc_i | input | 1 | One transaction from this store is serviced this cycle |
| starve_lim_i | input | LIM_W | Starvation limit in ticks |
| run_len_i | input | RUN_W | Services to complete before leaving CRIT |
| hold_min_i | input | HOLD_W | Cycles spent in COOL |
| crit_o | output | 1 | Store is critical |
| state_o | output | 2 | Encoded state (0 NORMAL, 1 CRIT, 2 COOL) |

## Verification
The assertions assume three things about the inputs: `pend_i` and `svc_i` are synchronous to `clk`, a service strobe is counted once for each cycle it is high, and `tick_ext_i` is a single-cycle pulse when used. The check on tick spacing applies only to the internal source. The bench drives every input on the falling edge and holds `tick_ext_i` low because the default build uses the internal tick. It changes the programmable fields only between ticks, which keeps each comparison defined.

// File: rtl/xs_pkg.sv
package xs_pkg;

    // Tracker state encoding, visible on state_o
    typedef enum logic [1:0] {
        XS_NORMAL = 2'd0,
        XS_CRIT   = 2'd1,
        XS_COOL   = 2'd2
    } xs_state_e;

endpackage

// File: rtl/xs_tick_gen.sv
module xs_tick_gen #(
    parameter int TICK_PERIOD  = 32,
    parameter bit USE_EXT_TICK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tick_i,
    output logic tick_o
);

    localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

    generate
        if (USE_EXT_TICK) begin : g_ext
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign tick_o = ext_tick_i;
        end else begin : g_int
            logic          unused_ext;
            logic [CW-1:0] phase_q;

            assign unused_ext = ext_tick_i;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    phase_q <= '0;
                else if (phase_q == LAST)
                    phase_q <= '0;
                else
                    phase_q <= phase_q + 1'b1;
            end

            assign tick_o = (phase_q == LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R1
        end
    endgenerate

endmodule

// File: rtl/xs_starve_cnt.sv
module xs_starve_cnt #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             pend_i,
    input  logic             svc_i,
    input  logic             tick_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             expire_o
);

    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W:0]   cnt_inc;
    logic             waiting;

    assign waiting = enable_i && pend_i && !svc_i;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    // Count consecutive ticks while starving; saturate at the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!waiting)
            cnt_q <= '0;
        else if (tick_i && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    // Limit read at each tick; zero behaves as one
    assign expire_o = waiting && tick_i && (cnt_inc >= {1'b0, limit_i});

    AST_STARVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_i || !pend_i) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/xs_span_cnt.sv
module xs_span_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    // Cleared outside the owning state, so it starts at zero on entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active_i)
            cnt_q <= '0;
        else if (step_i && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = active_i && step_i && (cnt_inc >= {1'b0, limit_i});

endmodule

// File: rtl/xs_starve_tracker.sv
module xs_starve_tracker #(
    parameter int TICK_PERIOD  = 32,
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int LIM_W        = 8,
    parameter int RUN_W        = 8,
    parameter int HOLD_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ext_i,
    input  logic              pend_i,
    input  logic              svc_i,
    input  logic [LIM_W-1:0]  starve_lim_i,
    input  logic [RUN_W-1:0]  run_len_i,
    input  logic [HOLD_W-1:0] hold_min_i,
    output logic              crit_o,
    output logic [1:0]        state_o
);

    import xs_pkg::*;

    xs_state_e state_q;
    xs_state_e state_d;
    logic      tick;
    logic      starve_exp;
    logic      run_done;
    logic      hold_done;

    xs_tick_gen #(
        .TICK_PERIOD (TICK_PERIOD),
        .USE_EXT_TICK(USE_EXT_TICK)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_tick_i(tick_ext_i),
        .tick_o    (tick)
    );

    xs_starve_cnt #(.LIM_W(LIM_W)) u_starve (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(state_q == XS_NORMAL),
        .pend_i  (pend_i),
        .svc_i   (svc_i),
        .tick_i  (tick),
        .limit_i (starve_lim_i),
        .expire_o(starve_exp)
    );

    // Service run inside CRIT
    xs_span_cnt #(.W(RUN_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(state_q == XS_CRIT),
        .step_i  (svc_i),
        .limit_i (run_len_i),
        .done_o  (run_done)
    );

    // Cycle count inside COOL
    xs_span_cnt #(.W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(state_q == XS_COOL),
        .step_i  (1'b1),
        .limit_i (hold_min_i),
        .done_o  (hold_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_NORMAL: if (starve_exp) state_d = XS_CRIT;
            XS_CRIT:   if (run_done)   state_d = XS_COOL;
            XS_COOL:   if (hold_done)  state_d = XS_NORMAL;
            default:                   state_d = XS_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= XS_NORMAL;
        else
            state_q <= state_d;
    end

    always_comb begin
        crit_o  = (state_q == XS_CRIT);
        state_o = state_q;
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd3); // R2

    AST_CRIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_CRIT && $past(state_q) != XS_CRIT)
        |-> ($past(state_q) == XS_NORMAL && $past(tick) && $past(pend_i))); // R3

    AST_COOL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_COOL && $past(state_q) != XS_COOL)
        |-> ($past(state_q) == XS_CRIT && $past(svc_i))); // R5

    AST_NORMAL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_NORMAL && $past(state_q) != XS_NORMAL)
        |-> ($past(state_q) == XS_COOL)); // R6

    AST_CRIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_CRIT && !svc_i) |=> (state_q == XS_CRIT)); // R9

endmodule

// File: tb/xs_starve_tracker_test.sv
module xs_starve_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ext = 1'b0;
    logic       pend = 1'b0;
    logic       svc = 1'b0;
    logic [7:0] lim = 8'd0;
    logic [7:0] run = 8'd1;
    logic [7:0] hold = 8'd1;
    logic       crit_o;
    logic [1:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    xs_starve_tracker uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_ext_i  (tick_ext),
        .pend_i      (pend),
        .svc_i       (svc),
        .starve_lim_i(lim),
        .run_len_i   (run),
        .hold_min_i  (hold),
        .crit_o      (crit_o),
        .state_o     (state_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edges);
        end
    endtask

    // Park at a falling edge where the next rising edge consumes a tick
    task automatic to_tick();
        while ((edges % 32) != 31) @(negedge clk);
    endtask

    task automatic arm(input int l);
        lim = 8'(l); pend = 1'b0; svc = 1'b0;
        @(negedge clk);
        if ((edges % 32) == 31) @(negedge clk);
        pend = 1'b1;
    endtask

    task automatic t_reset();
        check("R2 reset state", state_o, 0);
        check("R2 reset crit", crit_o, 0);
    endtask

    task automatic t_starve(input int l);
        int n = (l == 0) ? 1 : l;
        arm(l);
        for (int k = 1; k <= n; k++) begin
            to_tick();
            check("R3 not critical before limit", state_o, 0);
            @(negedge clk);
        end
        check("R3 critical at limit", state_o, 1);
        check("R7 crit high in CRIT", crit_o, 1);
        check("R1 entry on tick edge", edges % 32, 0);
    endtask

    task automatic t_run(input int r, input int h);
        int rn = (r == 0) ? 1 : r;
        int hn = (h == 0) ? 1 : h;
        int crit_seen = 0;
        run = 8'(r); hold = 8'(h);
        for (int i = 1; i <= rn; i++) begin
            check("R5 still CRIT before run done", state_o, 1);
            svc = 1'b1;
            @(negedge clk);
            svc = 1'b0;
        end
        check("R5 COOL after run", state_o, 2);
        for (int c = 1; c < hn; c++) begin
            crit_seen += crit_o;
            @(negedge clk);
        end
        crit_seen += crit_o;
        check("R7 crit low through COOL", crit_seen, 0);
        check("R6 COOL until hold end", state_o, 2);
        @(negedge clk);
        check("R6 NORMAL after hold", state_o, 0);
        pend = 1'b0;
    endtask

    task automatic t_clear();
        arm(2);
        to_tick(); @(negedge clk);
        svc = 1'b1; @(negedge clk); svc = 1'b0;
        to_tick(); @(negedge clk);
        check("R4 service restarted count", state_o, 0);
        to_tick(); @(negedge clk);
        check("R4 critical after fresh ticks", state_o, 1);
        t_run(1, 1);
        arm(2);
        to_tick(); @(negedge clk);
        pend = 1'b0; @(negedge clk); pend = 1'b1;
        to_tick(); @(negedge clk);
        check("R4 idle cycle restarted count", state_o, 0);
        to_tick(); @(negedge clk);
        check("R4 critical after idle restart", state_o, 1);
        t_run(2, 3);
    endtask

    task automatic t_lim_change();
        arm(5);
        to_tick(); @(negedge clk);
        lim = 8'd2;
        to_tick();
        check("R8 normal before new limit tick", state_o, 0);
        @(negedge clk);
        check("R8 new limit applied", state_o, 1);
        t_run(1, 2);
    endtask

    task automatic t_crit_hold();
        t_starve(1);
        pend = 1'b0;
        repeat (40) @(negedge clk);
        check("R9 stays CRIT without service", state_o, 1);
        check("R9 crit held", crit_o, 1);
        pend = 1'b1;
        t_run(3, 40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_starve(3);
        t_run(2, 5);
        t_starve(0);
        t_run(0, 0);
        t_clear();
        t_lim_change();
        t_crit_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule